// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a watchdog timer that escalates in two steps. Software sets an 8-bit terminal count and arms one or both stages through a small control register. A prescaled tick counter then runs toward that count. Any kick, or a rewrite of the terminal count, restarts the count. If the count is reached, stage 1 fires a one-cycle pulse. The pulse appears on a non-maskable-interrupt line or on an init line, chosen by a select bit. A fixed number of cycles later, stage 2 fires a one-cycle reset pulse. That gap gives software a window to recover, and a kick inside the window cancels the pending reset.

Each stage has its own enable bit and its own sticky monitor flag. A stage that fires sets its flag, and software clears the flag by writing 0 to it. At a timeout both enable bits clear themselves, so the watchdog never re-arms without a fresh software write. The inter-stage gap and the tick prescale are parameters counted in clock cycles.

Top module: `esc_watchdog`

## Requirements
- R1: While `rst_n` is low, and right after it is released, both registers read 0 and the three pulse outputs are low.
- R2: Register address 0 is the control register and address 1 is the terminal count. Reads are combinational from `reg_addr`. The control bits are: bit 5 stage-2 enable, bit 4 stage-1 enable, bit 3 stage-1 select (0 selects the interrupt line, 1 selects the init line), bit 2 stage-2 monitor, bit 1 stage-1 monitor. Bits 7, 6 and 0 always read 0.
- R3: The watchdog is armed when either enable bit is 1. The timeout happens PRESCALE*L clock edges after the edge that armed or last reloaded the counter. L is the terminal count, except that a terminal count of 0 means L = 256. Stage-1 output appears at exactly that edge.
- R4: At a timeout with stage-1 enabled, exactly one of `stg1_nmi` (select = 0) or `stg1_init` (select = 1) pulses.
- R5: With stage-2 enabled at the timeout, `stg2_rst` pulses exactly GAP_CYCLES edges after the timeout edge. This holds even when stage 1 is disabled.
- R6: A stage that fires sets its monitor bit, and the bit stays 1. Writing 0 to a monitor bit clears it. Writing 1 to a monitor bit leaves it unchanged.
- R7: A stage whose enable bit is 0 at the timeout neither pulses nor sets its monitor bit. With both enables 0, no output ever pulses.
- R8: A timeout clears both enable bits. No further pulses follow until software re-arms the watchdog.
- R9: While the watchdog is armed, a `kick` pulse or a write to the terminal count restarts the timeout count from that edge.
- R10: A `kick` during the inter-stage gap cancels the pending stage-2 reset. The stage-2 monitor bit stays clear.
- R11: Every output pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 terminal count |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| kick | input | 1 | Watchdog refresh pulse |
| stg1_nmi | output | 1 | Stage-1 interrupt pulse |
| stg1_init | output | 1 | Stage-1 init pulse |
| stg2_rst | output | 1 | Stage-2 reset pulse |

## Verification
The timeout path is tried with several enable and select combinations:
- stage 1 alone on the interrupt line;
- both stages on the init line;
- stage 2 alone;
- neither stage.

Together these separate the routing of the select bit from the gating by each enable. Terminal counts of 1, 2, 3, 4 and 0 tell the ordinary count apart from the wrap to 256 ticks.

A run of kicks followed by silence, and a mid-count rewrite of the terminal count, show that both sources of reload restart the count from their own edge. A kick placed inside the gap shows that the reset is cancelled without disturbing the stage-1 monitor.

Write patterns mixing 0s and 1s on the monitor bits show that writes can clear a monitor bit but never set it.

// File: rtl/esc_wdog_pkg.sv
// Package: shared field layout and helpers for the escalating watchdog.
// Assumes an 8-bit register port; bit positions are fixed by software use.
package esc_wdog_pkg;

    localparam int REG_W = 8;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_TC   = 1'b1;

    localparam int BIT_S2_EN  = 5;
    localparam int BIT_S1_EN  = 4;
    localparam int BIT_SEL    = 3;
    localparam int BIT_S2_MON = 2;
    localparam int BIT_S1_MON = 1;

    // Field order matches the register bits 5 down to 1.
    typedef struct packed {
        logic s2_en;
        logic s1_en;
        logic sel_init;
        logic s2_mon;
        logic s1_mon;
    } wd_ctrl_t;

    // Place the control fields into their register image.
    function automatic logic [REG_W-1:0] pack_ctrl(wd_ctrl_t c);
        return {2'b00, c, 1'b0};
    endfunction

endpackage

// File: rtl/esc_wdog_regs.sv
// Control and terminal-count registers with readback.
// Assumes single-cycle writes. A timeout takes priority over a write to the
// enable bits in the same cycle. Monitor bits can only be cleared by writes.
module esc_wdog_regs
    import esc_wdog_pkg::*;
#(
    parameter int TC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             expire,
    input  logic             s2_fire,
    output wd_ctrl_t         ctrl,
    output logic [TC_W-1:0]  tc,
    output logic             tc_wr,
    output logic [REG_W-1:0] rdata
);

    logic ctrl_wr;
    logic unused_wbits;

    assign ctrl_wr      = wr && (addr == ADDR_CTRL);
    assign tc_wr        = wr && (addr == ADDR_TC);
    assign unused_wbits = ^{wdata[7:6], wdata[0]};

    // Control register: software fields, timeout self-clear, sticky monitors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.s2_en    <= wdata[BIT_S2_EN];
                ctrl.s1_en    <= wdata[BIT_S1_EN];
                ctrl.sel_init <= wdata[BIT_SEL];
                ctrl.s2_mon   <= ctrl.s2_mon & wdata[BIT_S2_MON];
                ctrl.s1_mon   <= ctrl.s1_mon & wdata[BIT_S1_MON];
            end
            if (expire) begin
                ctrl.s1_en <= 1'b0;
                ctrl.s2_en <= 1'b0;
                if (ctrl.s1_en) ctrl.s1_mon <= 1'b1;
            end
            if (s2_fire) ctrl.s2_mon <= 1'b1;
        end
    end

    // Terminal-count register.
    always_ff @(posedge clk) begin
        if (!rst_n)     tc <= '0;
        else if (tc_wr) tc <= wdata[TC_W-1:0];
    end

    // Combinational readback of the selected register.
    always_comb begin
        rdata = (addr == ADDR_TC) ? REG_W'(tc) : pack_ctrl(ctrl);
    end

    assert_en_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!ctrl.s1_en && !ctrl.s2_en));

    assert_mon_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl.s1_en) |=> ctrl.s1_mon);

    assert_mon_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.s2_mon && !ctrl_wr) |=> ctrl.s2_mon);

endmodule

// File: rtl/esc_wdog_timer.sv
// Prescaled timeout counter. It counts ticks while armed and flags the cycle
// in which the tick count reaches the terminal count (0 means 2**TC_W).
// Assumes a reload always coincides with any change of tc.
module esc_wdog_timer #(
    parameter int TC_W     = 8,
    parameter int PRESCALE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            armed,
    input  logic            reload,
    input  logic [TC_W-1:0] tc,
    output logic            expire
);

    localparam int CNT_W = TC_W + 1;
    localparam int PS_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic             run;
    logic             tick;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] tick_cnt;
    logic             last_tick;

    assign run       = armed && !reload;
    assign limit     = (tc == '0) ? {1'b1, {TC_W{1'b0}}} : {1'b0, tc};
    assign last_tick = (tick_cnt == (limit - 1'b1));
    assign expire    = tick && last_tick;

    generate
        if (PRESCALE == 1) begin : g_no_prescale
            assign tick = run;
        end else begin : g_prescale
            logic [PS_W-1:0] pre_cnt;
            // Divide the clock down to one tick every PRESCALE cycles.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)                  pre_cnt <= '0;
                else if (pre_cnt == PS_W'(PRESCALE-1)) pre_cnt <= '0;
                else                                 pre_cnt <= pre_cnt + 1'b1;
            end
            assign tick = run && (pre_cnt == PS_W'(PRESCALE-1));
        end
    endgenerate

    // Tick counter: cleared when idle or reloaded, wraps at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  tick_cnt <= '0;
        else if (tick)       tick_cnt <= last_tick ? '0 : tick_cnt + 1'b1;
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (tick_cnt < limit));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !expire);

endmodule

// File: rtl/esc_wdog_gap.sv
// Inter-stage delay. It starts at a timeout with stage 2 enabled and flags
// the cycle that ends GAP_CYCLES cycles later. A kick cancels it.
// Assumes GAP_CYCLES >= 1, and that start never arrives while already pending.
module esc_wdog_gap #(
    parameter int GAP_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic pending,
    output logic fire
);

    localparam int GC_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

    logic [GC_W-1:0] gap_cnt;
    logic            gap_end;

    assign gap_end = (gap_cnt == GC_W'(GAP_CYCLES-1));
    assign fire    = pending && !cancel && gap_end;

    // Track the pending reset and count its delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            gap_cnt <= '0;
        end else if (start) begin
            pending <= 1'b1;
            gap_cnt <= '0;
        end else if (pending && (cancel || gap_end)) begin
            pending <= 1'b0;
            gap_cnt <= '0;
        end else if (pending) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && cancel && !start) |=> !pending);

    assert_fire_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !start) |=> !pending);

endmodule

// File: rtl/esc_watchdog.sv
// Top: two-stage escalating watchdog. Wires the registers, the timeout
// counter and the inter-stage delay, and registers the three output pulses.
// Assumes kick is synchronous to clk.
module esc_watchdog
    import esc_wdog_pkg::*;
#(
    parameter int TC_W       = 8,
    parameter int PRESCALE   = 4,
    parameter int GAP_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       kick,
    output logic       stg1_nmi,
    output logic       stg1_init,
    output logic       stg2_rst
);

    wd_ctrl_t        ctrl;
    logic [TC_W-1:0] tc;
    logic            tc_wr;
    logic            expire;
    logic            s1_fire;
    logic            s2_fire;
    logic            gap_pending;
    logic            armed;

    assign armed   = ctrl.s1_en || ctrl.s2_en;
    assign s1_fire = expire && ctrl.s1_en;

    esc_wdog_regs #(.TC_W(TC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .expire  (expire),
        .s2_fire (s2_fire),
        .ctrl    (ctrl),
        .tc      (tc),
        .tc_wr   (tc_wr),
        .rdata   (reg_rdata)
    );

    esc_wdog_timer #(.TC_W(TC_W), .PRESCALE(PRESCALE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (armed),
        .reload (kick || tc_wr),
        .tc     (tc),
        .expire (expire)
    );

    esc_wdog_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (expire && ctrl.s2_en),
        .cancel  (kick),
        .pending (gap_pending),
        .fire    (s2_fire)
    );

    // Output pulses: one registered cycle per firing event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_nmi  <= 1'b0;
            stg1_init <= 1'b0;
            stg2_rst  <= 1'b0;
        end else begin
            stg1_nmi  <= s1_fire && !ctrl.sel_init;
            stg1_init <= s1_fire &&  ctrl.sel_init;
            stg2_rst  <= s2_fire;
        end
    end

    assert_stage1_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(stg1_nmi && stg1_init));

    assert_nmi_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stg1_nmi |=> !stg1_nmi);

    assert_init_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stg1_init |=> !stg1_init);

    assert_rst_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stg2_rst |=> !stg2_rst);

    assert_rst_needs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s2_fire |-> gap_pending);

endmodule

// File: tb/test_esc_watchdog.sv
module test_esc_watchdog;

    localparam int PS  = 4;
    localparam int GAP = 20;

    localparam int EV_NMI  = 1;
    localparam int EV_INIT = 2;
    localparam int EV_RST  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       kick = 1'b0;
    logic       stg1_nmi, stg1_init, stg2_rst;

    esc_watchdog #(.TC_W(8), .PRESCALE(PS), .GAP_CYCLES(GAP)) i_esc_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .kick      (kick),
        .stg1_nmi  (stg1_nmi),
        .stg1_init (stg1_init),
        .stg2_rst  (stg2_rst)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;

    ev_t exp_q[$];
    int  n_cmp = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  done  = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each observed pulse with the head of the queue.
    task automatic see(input int k);
        ev_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R7/R8: actual pulse kind %0d at cycle %0d expected none", k, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.at != cyc) begin
                n_bad++;
                $display("FAIL %s: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                         e.req, k, cyc, e.kind, e.at);
            end
        end
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (stg1_nmi)  see(EV_NMI);
            if (stg1_init) see(EV_INIT);
            if (stg2_rst)  see(EV_RST);
        end
    end

    task automatic push(input int kind, input int at, input string req);
        ev_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d, output int c0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        c0 = cyc;
    endtask

    task automatic do_kick(output int c0);
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        c0 = cyc;
    endtask

    task automatic rd_chk(input logic a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0;
        idle(3);
        // R1: values during reset.
        @(negedge clk);
        chk("R1 outputs in reset", {stg1_nmi, stg1_init, stg2_rst}, 3'b000);
        rst_n = 1'b1;
        rd_chk(1'b0, 8'h00, "R1 ctrl after reset");
        rd_chk(1'b1, 8'h00, "R1 tc after reset");

        // R2: unused bits read 0; the select bit is kept.
        wr_reg(1'b0, 8'hC9, c0);
        rd_chk(1'b0, 8'h08, "R2 ctrl unused bits");
        wr_reg(1'b1, 8'h5A, c0);
        rd_chk(1'b1, 8'h5A, "R2 tc readback");

        // R7: both enables off, no pulses.
        wr_reg(1'b1, 8'h01, c0);
        wr_reg(1'b0, 8'h00, c0);
        idle(100);

        // R3/R4: stage 1 alone on the interrupt line, tc=3.
        wr_reg(1'b1, 8'h03, c0);
        wr_reg(1'b0, 8'h10, c0);
        push(EV_NMI, c0 + 3*PS, "R3/R4 nmi tc=3");
        idle(3*PS + GAP + 20);
        rd_chk(1'b0, 8'h02, "R6/R7/R8 ctrl after stage-1 only");

        // R6: writing 1 to a monitor keeps it, writing 0 clears it.
        wr_reg(1'b0, 8'h02, c0);
        rd_chk(1'b0, 8'h02, "R6 write 1 keeps monitor");
        wr_reg(1'b0, 8'h00, c0);
        rd_chk(1'b0, 8'h00, "R6 write 0 clears monitor");
        wr_reg(1'b0, 8'h06, c0);
        rd_chk(1'b0, 8'h00, "R6 write 1 cannot set monitor");

        // R4/R5: both stages on the init line, tc=2.
        wr_reg(1'b1, 8'h02, c0);
        wr_reg(1'b0, 8'h38, c0);
        push(EV_INIT, c0 + 2*PS, "R4 init tc=2");
        push(EV_RST, c0 + 2*PS + GAP, "R5 reset after gap");
        idle(2*PS + GAP + 30);
        rd_chk(1'b0, 8'h0E, "R6/R8 ctrl after both stages");
        wr_reg(1'b0, 8'h0C, c0);
        rd_chk(1'b0, 8'h0C, "R6 clear only stage-1 monitor");
        wr_reg(1'b0, 8'h00, c0);
        rd_chk(1'b0, 8'h00, "R6 clear all");

        // R5/R7: stage 2 alone, tc=1.
        wr_reg(1'b1, 8'h01, c0);
        wr_reg(1'b0, 8'h20, c0);
        push(EV_RST, c0 + PS + GAP, "R5 reset with stage 1 off");
        idle(PS + GAP + 30);
        rd_chk(1'b0, 8'h04, "R7 stage-1 monitor stays clear");
        wr_reg(1'b0, 8'h00, c0);

        // R9: repeated kicks hold off the timeout, tc=4.
        wr_reg(1'b1, 8'h04, c0);
        wr_reg(1'b0, 8'h10, c0);
        for (int i = 0; i < 5; i++) begin
            idle(10);
            do_kick(c0);
        end
        push(EV_NMI, c0 + 4*PS, "R9 kick reload");
        idle(4*PS + 20);
        wr_reg(1'b0, 8'h00, c0);

        // R9: a terminal-count write reloads the count.
        wr_reg(1'b1, 8'h03, c0);
        wr_reg(1'b0, 8'h10, c0);
        idle(8);
        wr_reg(1'b1, 8'h03, c0);
        push(EV_NMI, c0 + 3*PS, "R9 tc write reload");
        idle(3*PS + 20);
        wr_reg(1'b0, 8'h00, c0);

        // R10: a kick in the gap cancels the reset.
        wr_reg(1'b1, 8'h01, c0);
        wr_reg(1'b0, 8'h30, c0);
        push(EV_NMI, c0 + PS, "R10 nmi before cancel");
        idle(PS + 5);
        do_kick(c0);
        idle(GAP + 20);
        rd_chk(1'b0, 8'h02, "R10 stage-2 monitor clear after cancel");
        wr_reg(1'b0, 8'h00, c0);

        // R3: terminal count 0 means 256 ticks.
        wr_reg(1'b1, 8'h00, c0);
        wr_reg(1'b0, 8'h10, c0);
        push(EV_NMI, c0 + 256*PS, "R3 tc=0 wraps to 256");
        idle(256*PS + 40);
        rd_chk(1'b0, 8'h02, "R8 no re-arm after wrap");

        chk("R5/R11 all expected pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule